// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives a serial bit clock from a faster source clock. The division ratio is the product of a linear mantissa and a power of two. A prescale stage counts through 1 to 16 source cycles. A binary stage, stepped once per prescale wrap, counts through 2^0 to 2^15 prescale periods. The combined ratio is therefore `(pre_sel_i + 1) * 2^exp_sel_i`, which can be any value from 1 up to 16 * 32768 source cycles.

The output is a registered square wave. Each period opens with its high phase. An edge strobe marks the last source cycle of every period. A controller that needs a certain bit rate picks the smallest mantissa and exponent whose product is at least the wanted ratio, then holds the enable high.

Changes to the divide fields are latched only when a period closes, so a reprogramming never cuts a period short. When the enable drops, the block returns to an idle, low state.

Top module: `spi_clk_div_top`

## Requirements
- R1: While enabled with steady fields, `edge_o` pulses once every N source cycles, where N = (P+1) * 2^E, P = `pre_sel_i` and E = `exp_sel_i`.
- R2: The 4-bit prescale field P sets the mantissa to P+1. P = 0 gives a mantissa of 1 and P = 15 gives 16.
- R3: The 4-bit exponent field E is used directly as the power of two, so E = 15 multiplies the period by 32768.
- R4: Within each period, `sclk_o` is high for the first ceil(N/2) cycles and low for the remaining floor(N/2). For N = 1, `sclk_o` stays high.
- R5: `edge_o` is high exactly in the last cycle of each period, with that period's ratio. With both fields at 0 it is high on every enabled cycle.
- R6: A change of P or E during a running period has no effect until the cycle after `edge_o`. The new ratio governs the period that follows.
- R7: A clock edge that samples `en_i` low leaves `sclk_o` and `edge_o` low afterwards. The first edge that samples `en_i` high starts a fresh period at its first cycle, with `sclk_o` high, using the fields sampled on that edge.
- R8: During reset (`rst_ni` low), `sclk_o` and `edge_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src_i | input | 1 | Source clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds both stages at zero |
| pre_sel_i | input | 4 | Prescale field, mantissa minus one |
| exp_sel_i | input | 4 | Exponent field, power of two |
| sclk_o | output | 1 | Divided serial clock, registered |
| edge_o | output | 1 | One-cycle strobe in the last cycle of each period |

## Verification
The properties assume that `en_i`, `pre_sel_i` and `exp_sel_i` are synchronous to the source clock and settled before each rising edge. They also assume that the fields may change on any cycle, including in the middle of a period. The stimulus changes every input only on the falling edge. Random phases draw new fields and enable levels at arbitrary points inside periods, so the field latching and the restart paths are exercised. The exponent is kept small in the random phases so that many periods complete. The extreme exponent is covered by one directed period.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  // Default widths of the two divide fields.
  localparam int unsigned DEF_PRE_W = 4;
  localparam int unsigned DEF_EXP_W = 4;
endpackage

// File: rtl/spi_div_stage.sv
// One counting stage: counts 0..lim_i, advancing when inc_i is high.
module spi_div_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] cnt_q_o,
  output logic [W-1:0] cnt_d_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign wrap_o = (cnt_q == lim_i);
  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = wrap_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;
endmodule

// File: rtl/spi_div_phase.sv
// Output stage: registers the square wave and the period-end strobe
// from the next-state counter values.
module spi_div_phase #(
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned POST_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_d_i,
  input  logic [PRE_W-1:0]  pre_cnt_d_i,
  input  logic [POST_W-1:0] post_cnt_d_i,
  input  logic [PRE_W-1:0]  pre_lim_d_i,
  input  logic [POST_W-1:0] post_mask_d_i,
  output logic              sclk_o,
  output logic              edge_o
);
  logic [POST_W-1:0] post_half;
  logic [PRE_W:0]    pre_half;
  logic              high_d;
  logic              term_d;
  logic              sclk_q;
  logic              edge_q;

  // Top bit of the binary range; zero when the exponent is zero.
  assign post_half = post_mask_d_i ^ (post_mask_d_i >> 1);
  // ceil((lim+1)/2) for a prescale-only ratio.
  assign pre_half  = ({1'b0, pre_lim_d_i} + 2'd2) >> 1;

  always_comb begin
    if (post_mask_d_i == '0) begin
      high_d = ({1'b0, pre_cnt_d_i} < pre_half);
    end else begin
      high_d = ((post_cnt_d_i & post_half) == '0);
    end
  end

  assign term_d = run_d_i && (pre_cnt_d_i == pre_lim_d_i)
                          && (post_cnt_d_i == post_mask_d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      sclk_q <= run_d_i && high_d;
      edge_q <= term_d;
    end
  end

  assign sclk_o = sclk_q;
  assign edge_o = edge_q;
endmodule

// File: rtl/spi_clk_div_top.sv
module spi_clk_div_top #(
  parameter int unsigned PRE_W = spi_div_pkg::DEF_PRE_W,
  parameter int unsigned EXP_W = spi_div_pkg::DEF_EXP_W
) (
  input  logic             clk_src_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] pre_sel_i,
  input  logic [EXP_W-1:0] exp_sel_i,
  output logic             sclk_o,
  output logic             edge_o
);
  localparam int unsigned POST_W = (1 << EXP_W) - 1;

  function automatic logic [POST_W-1:0] exp_mask(input logic [EXP_W-1:0] e);
    logic [POST_W:0] t;
    t = ({{POST_W{1'b0}}, 1'b1} << e) - 1'b1;
    return t[POST_W-1:0];
  endfunction

  logic              run_q;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [EXP_W-1:0]  exp_q, exp_d;
  logic [PRE_W-1:0]  pre_cnt_q, pre_cnt_d;
  logic [POST_W-1:0] post_cnt_q, post_cnt_d;
  logic              pre_wrap, post_wrap;
  logic              stage_clr;
  logic              term_cur;
  logic              cfg_load;
  logic [POST_W-1:0] post_lim_q, post_lim_d;

  assign stage_clr  = !en_i || !run_q;
  assign term_cur   = run_q && pre_wrap && post_wrap;
  assign cfg_load   = !run_q || term_cur;
  assign post_lim_q = exp_mask(exp_q);
  assign post_lim_d = exp_mask(exp_d);

  // Field latch next state: only at idle or at a period's last cycle.
  always_comb begin
    pre_d = pre_q;
    exp_d = exp_q;
    if (cfg_load) begin
      pre_d = pre_sel_i;
      exp_d = exp_sel_i;
    end
  end

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pre_q <= '0;
      exp_q <= '0;
    end else begin
      run_q <= en_i;
      if (cfg_load) begin
        pre_q <= pre_d;
        exp_q <= exp_d;
      end
    end
  end

  spi_div_stage #(.W(PRE_W)) u_pre (
    .clk_i   (clk_src_i),
    .rst_ni  (rst_ni),
    .clr_i   (stage_clr),
    .inc_i   (1'b1),
    .lim_i   (pre_q),
    .cnt_q_o (pre_cnt_q),
    .cnt_d_o (pre_cnt_d),
    .wrap_o  (pre_wrap)
  );

  spi_div_stage #(.W(POST_W)) u_post (
    .clk_i   (clk_src_i),
    .rst_ni  (rst_ni),
    .clr_i   (stage_clr),
    .inc_i   (pre_wrap),
    .lim_i   (post_lim_q),
    .cnt_q_o (post_cnt_q),
    .cnt_d_o (post_cnt_d),
    .wrap_o  (post_wrap)
  );

  spi_div_phase #(.PRE_W(PRE_W), .POST_W(POST_W)) u_phase (
    .clk_i         (clk_src_i),
    .rst_ni        (rst_ni),
    .run_d_i       (en_i),
    .pre_cnt_d_i   (pre_cnt_d),
    .post_cnt_d_i  (post_cnt_d),
    .pre_lim_d_i   (pre_d),
    .post_mask_d_i (post_lim_d),
    .sclk_o        (sclk_o),
    .edge_o        (edge_o)
  );

  logic unused_cnt;
  assign unused_cnt = ^{pre_cnt_q, post_cnt_q};
endmodule

// File: rtl/spi_clk_div_chk.sv
module spi_clk_div_chk #(
  parameter int unsigned PRE_W = 4,
  parameter int unsigned EXP_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             sclk_o,
  input logic             edge_o,
  input logic             run_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [EXP_W-1:0] exp_q
);
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sclk_o && !edge_o)); // R7

  AST_RESTART_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && en_i) |=> sclk_o); // R4

  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> ($past(edge_o) || !$past(run_q))); // R1

  AST_HIGH_EDGE_UNITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && sclk_o) |-> (pre_q == '0 && exp_q == '0)); // R5

  AST_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && !$past(edge_o)) |-> ($stable(pre_q) && $stable(exp_q))); // R6
endmodule

bind spi_clk_div_top spi_clk_div_chk #(.PRE_W(PRE_W), .EXP_W(EXP_W)) chk_i (
  .clk_i  (clk_src_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .sclk_o (sclk_o),
  .edge_o (edge_o),
  .run_q  (run_q),
  .pre_q  (pre_q),
  .exp_q  (exp_q)
);

// File: tb/spi_clk_div_top_tb_top.sv
module spi_clk_div_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] pre_sel;
  logic [3:0] exp_sel;
  logic       sclk;
  logic       edg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference model state
  bit m_run = 1'b0;
  int m_pos = 0;
  int m_n   = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_clk_div_top dut_i (
    .clk_src_i (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .pre_sel_i (pre_sel),
    .exp_sel_i (exp_sel),
    .sclk_o    (sclk),
    .edge_o    (edg)
  );

  function automatic int ratio(input int p, input int e);
    return (p + 1) << e;
  endfunction

  function automatic bit exp_sclk();
    return m_run && (m_pos < (m_n + 1) / 2);
  endfunction

  function automatic bit exp_edge();
    return m_run && (m_pos == m_n - 1);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Model of one rising edge given the inputs sampled there.
  task automatic model_edge(input bit e_n, input int p, input int e);
    if (!e_n) begin
      m_run = 1'b0;
      m_pos = 0;
    end else if (!m_run) begin
      m_run = 1'b1;
      m_pos = 0;
      m_n   = ratio(p, e);
    end else if (m_pos == m_n - 1) begin
      m_pos = 0;
      m_n   = ratio(p, e);
    end else begin
      m_pos++;
    end
  endtask

  // Called at a falling edge: drive, predict, wait one cycle, compare.
  task automatic step(input bit e_n, input int p, input int e);
    en      = e_n;
    pre_sel = 4'(p);
    exp_sel = 4'(e);
    model_edge(e_n, p, e);
    @(negedge clk);
    if (!m_run) begin
      check("R7 sclk idle", int'(sclk), 0);
      check("R7 edge idle", int'(edg), 0);
    end else begin
      check("R4 sclk phase", int'(sclk), int'(exp_sclk()));
      check("R5 edge strobe", int'(edg), int'(exp_edge()));
    end
  endtask

  // Start from idle and run one full period plus one cycle.
  task automatic run_period(input int p, input int e, input string tag);
    int n;
    int first_edge;
    int hi;
    n = ratio(p, e);
    first_edge = 0;
    hi = 0;
    step(1'b0, p, e);
    for (int i = 1; i <= n + 1; i++) begin
      step(1'b1, p, e);
      if (edg && first_edge == 0) first_edge = i;
      if (sclk && i <= n) hi++;
    end
    check({tag, " period length"}, first_edge, n);
    check("R4 high count", hi, (n + 1) / 2);
  endtask

  initial begin
    int p;
    int e;
    int len;
    int cnt;
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0;
    en = 1'b0;
    pre_sel = '0;
    exp_sel = '0;
    repeat (3) @(negedge clk);
    check("R8 reset sclk", int'(sclk), 0);
    check("R8 reset edge", int'(edg), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed ratios
    run_period(0, 0, "R5 unity");
    run_period(1, 0, "R1 two");
    run_period(2, 0, "R1 odd three");
    run_period(15, 0, "R2 sixteen");
    run_period(4, 2, "R1 twenty");
    run_period(15, 3, "R2 R3 mixed");
    run_period(0, 15, "R3 max exponent");

    // R6: reprogram mid-period; the running period keeps ratio 8.
    step(1'b0, 3, 1);
    cnt = 0;
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 3, 1);
      cnt++;
    end
    while (!edg && cnt < 20) begin
      step(1'b1, 0, 0);
      cnt++;
    end
    check("R6 old ratio kept", cnt, 8);
    step(1'b1, 0, 0);
    check("R6 new ratio edge", int'(edg), 1);
    step(1'b1, 0, 0);
    check("R6 new ratio edge again", int'(edg), 1);

    // R7: disable mid-period, then restart
    step(1'b1, 5, 1);
    step(1'b1, 5, 1);
    step(1'b0, 5, 1);
    check("R7 idle after drop", int'(sclk), 0);
    step(1'b1, 2, 0);
    check("R7 restart high", int'(sclk), 1);

    // Constrained random phases
    for (int seg = 0; seg < 60; seg++) begin
      p = int'($urandom_range(15, 0));
      e = int'($urandom_range(4, 0));
      len = int'($urandom_range(80, 1));
      for (int c = 0; c < len; c++) begin
        if ($urandom_range(9, 0) == 0) begin
          p = int'($urandom_range(15, 0));
          e = int'($urandom_range(4, 0));
        end
        step($urandom_range(19, 0) != 0, p, e);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule